// File: doc/BRIEF.md
# Power-Fail Strobe Gate for Battery-Backed Memory

This block sits between a host's active-low chip-enable and write-enable strobes and a memory array. While the supply is healthy, both strobes pass straight through. When a digital power-fail flag is raised, the block blocks both strobes so the memory cannot be corrupted while the supply collapses. A strobe that is already low at that moment may finish its cycle, but a grace timer limits how long it can stay low.

The block also drives an active-low power-fail flag for the rest of the system. When the supply comes back, the strobes stay blocked for a programmable hold-off time so the memory sees no stray access while the rails settle. Reset puts the block in the failed state, so a hold-off interval always follows reset.

The power-fail flag is brought into the clock domain through a register chain. The grace and hold-off intervals are given in clock cycles as parameters.

Top module: `pf_strobe_gate`

## Requirements
- R1: While the block is in the normal (powered) state, `ceo_n` equals `cei_n` and `weo_n` equals `wei_n` in the same cycle.
- R2: `pfo_n` goes low after the second rising clock edge that samples `pf_in` high. It stays low as long as `pf_in` is held high, and it returns high after the second rising edge that samples `pf_in` low.
- R3: A strobe input that is high (idle) when the failure takes effect, at the third edge after `pf_in` rises, has its output forced high from that edge on.
- R4: A strobe input that is low when the failure takes effect keeps its output low until the input returns high. The output then goes high in that same cycle.
- R5: A strobe kept low under R4 is forced high at the edge that ends the GRACE_CYCLES-th cycle of holding, which is edge 3+GRACE_CYCLES after `pf_in` rises, even if its input is still low.
- R6: The chip-enable and write-enable paths each have their own hold decision and grace timer. Releasing one does not affect the other.
- R7: Once an output has been forced high during a failure, no input change drives it low again until the hold-off interval has ended.
- R8: After `pfo_n` returns high, both outputs stay high for RECOVER_CYCLES+2 further edges. They follow their inputs again from the next edge after that.
- R9: A power failure that occurs during the hold-off interval cancels it. A complete new hold-off interval is required after the next recovery.
- R10: While `rst_n` is low, `pfo_n` is low and both outputs are high, whatever the inputs. After reset is released with `pf_in` low, R8 timing applies as if power had just returned.

Reset and failure behaviour follows R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pf_in | input | 1 | Power-fail indication from the supply comparator, high while the supply is out of tolerance (asynchronous) |
| cei_n | input | 1 | Host chip enable, active low |
| wei_n | input | 1 | Host write enable, active low |
| ceo_n | output | 1 | Gated chip enable to the memory, active low |
| weo_n | output | 1 | Gated write enable to the memory, active low |
| pfo_n | output | 1 | Power-fail flag, active low |

## Verification
The bench builds the block with GRACE_CYCLES = 8 and RECOVER_CYCLES = 20 instead of the real-time defaults of 1.5 ms and 125 ms at 200 MHz. With these short intervals, the exact edge at which a held strobe times out and the exact edge at which hold-off ends can both be checked cycle by cycle.

The short hold-off also makes it cheap to raise a second failure in the middle of a recovery and confirm that the interval restarts. It also allows several full fail/recover rounds in one run, covering idle, active, timed-out and split-lane cases.

// File: rtl/pfg_pkg.sv
// Package pfg_pkg
// Shared state encodings for the power-fail strobe gate.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package pfg_pkg;

    // Supply condition as seen by the gate
    typedef enum logic [1:0] {
        PS_FAIL    = 2'd0,
        PS_RECOVER = 2'd1,
        PS_NORMAL  = 2'd2
    } pwr_state_t;

    // Per-strobe gating state
    typedef enum logic [1:0] {
        LN_BLOCK = 2'd0,
        LN_PASS  = 2'd1,
        LN_HOLD  = 2'd2
    } lane_state_t;

    // Number of strobe paths handled by the gate (chip enable, write enable)
    localparam int unsigned NUM_LANES = 2;

endpackage

// File: rtl/pfg_sync.sv
// Module pfg_sync
// Register chain that brings an asynchronous level into the clock domain.
// Assumes STAGES >= 2. Reset loads RESET_VAL into every stage so the
// output has a defined level from the first cycle.
module pfg_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the incoming level through the chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pfg_power_fsm.sv
// Module pfg_power_fsm
// Tracks the supply condition: failed, recovering (hold-off) or normal.
// A failure seen in any state returns to PS_FAIL. Recovery lasts exactly
// RECOVER_CYCLES cycles of pf_s low before PS_NORMAL is entered.
// Assumes pf_s is already synchronous. RECOVER_CYCLES >= 1.
module pfg_power_fsm
    import pfg_pkg::*;
#(
    parameter int unsigned RECOVER_CYCLES = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pf_s,
    output logic in_normal,
    output logic fail_now
);

    localparam int unsigned CW = $clog2(RECOVER_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(RECOVER_CYCLES - 1);

    pwr_state_t    state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    // State and hold-off counter registers; reset enters the failed state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_FAIL;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Next-state decision for the supply condition
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            PS_FAIL: begin
                if (!pf_s) begin
                    state_nx = PS_RECOVER;
                    cnt_nx   = '0;
                end
            end
            PS_RECOVER: begin
                if (pf_s) begin
                    state_nx = PS_FAIL;
                end else if (cnt == LAST) begin
                    state_nx = PS_NORMAL;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            PS_NORMAL: begin
                if (pf_s) begin
                    state_nx = PS_FAIL;
                end
            end
            default: begin
                state_nx = PS_FAIL;
            end
        endcase
    end

    assign in_normal = (state == PS_NORMAL);
    assign fail_now  = in_normal & pf_s;

endmodule

// File: rtl/pfg_lane.sv
// Module pfg_lane
// Gates one active-low strobe. In LN_PASS the output follows the input.
// On a failure event the lane either blocks at once (input idle) or lets
// the active cycle finish in LN_HOLD, bounded by GRACE_CYCLES. A blocked
// lane opens again only when the supply FSM reports normal operation.
// Assumes GRACE_CYCLES >= 1 and that fail_now is a one-cycle event that
// occurs only while open is high.
module pfg_lane
    import pfg_pkg::*;
#(
    parameter int unsigned GRACE_CYCLES = 300_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic open,
    input  logic fail_now,
    input  logic strobe_in_n,
    output logic strobe_out_n
);

    localparam int unsigned CW = $clog2(GRACE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(GRACE_CYCLES - 1);

    lane_state_t   state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    // Lane state and grace counter; reset leaves the strobe blocked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LN_BLOCK;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Next-state decision and output gating
    always_comb begin
        state_nx     = state;
        cnt_nx       = cnt;
        strobe_out_n = 1'b1;
        unique case (state)
            LN_PASS: begin
                strobe_out_n = strobe_in_n;
                if (fail_now) begin
                    if (strobe_in_n) begin
                        state_nx = LN_BLOCK;
                    end else begin
                        state_nx = LN_HOLD;
                        cnt_nx   = '0;
                    end
                end else if (!open) begin
                    state_nx = LN_BLOCK;
                end
            end
            LN_HOLD: begin
                strobe_out_n = strobe_in_n;
                if (strobe_in_n || (cnt == LAST)) begin
                    state_nx = LN_BLOCK;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            LN_BLOCK: begin
                strobe_out_n = 1'b1;
                if (open && !fail_now) begin
                    state_nx = LN_PASS;
                end
            end
            default: begin
                state_nx = LN_BLOCK;
            end
        endcase
    end

endmodule

// File: rtl/pf_strobe_gate.sv
// Module pf_strobe_gate
// Top of the power-fail strobe gate. Synchronises the power-fail flag,
// runs the supply FSM and gates the chip-enable and write-enable paths
// through one pfg_lane each. pfo_n mirrors the synchronised flag.
// Assumes pf_in is asynchronous and the strobes are synchronous to clk.
module pf_strobe_gate
    import pfg_pkg::*;
#(
    parameter int unsigned GRACE_CYCLES   = 300_000,
    parameter int unsigned RECOVER_CYCLES = 25_000_000,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pf_in,
    input  logic cei_n,
    input  logic wei_n,
    output logic ceo_n,
    output logic weo_n,
    output logic pfo_n
);

    logic                 pf_s;
    logic                 in_normal;
    logic                 fail_now;
    logic [NUM_LANES-1:0] strb_in_n;
    logic [NUM_LANES-1:0] strb_out_n;

    pfg_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pf_in),
        .q     (pf_s)
    );

    pfg_power_fsm #(
        .RECOVER_CYCLES (RECOVER_CYCLES)
    ) u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .pf_s      (pf_s),
        .in_normal (in_normal),
        .fail_now  (fail_now)
    );

    assign strb_in_n = {wei_n, cei_n};

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        pfg_lane #(
            .GRACE_CYCLES (GRACE_CYCLES)
        ) u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .open         (in_normal),
            .fail_now     (fail_now),
            .strobe_in_n  (strb_in_n[g]),
            .strobe_out_n (strb_out_n[g])
        );
    end

    assign ceo_n = strb_out_n[0];
    assign weo_n = strb_out_n[1];
    assign pfo_n = ~pf_s;

endmodule

// File: rtl/pfg_checker.sv
// Module pfg_checker
// Temporal checks for pf_strobe_gate, attached with bind below.
// Window checks use local counters so the grace and hold-off
// lengths never become $past depths.
module pfg_checker #(
    parameter int unsigned GRACE_CYCLES   = 300_000,
    parameter int unsigned RECOVER_CYCLES = 25_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic cei_n,
    input logic wei_n,
    input logic ceo_n,
    input logic weo_n,
    input logic pfo_n,
    input logic in_normal
);

    localparam int unsigned GW       = $clog2(GRACE_CYCLES + 2) + 1;
    localparam int unsigned HW       = $clog2(RECOVER_CYCLES + 3) + 1;
    localparam logic [GW-1:0] G_LIM  = GW'(GRACE_CYCLES);
    localparam logic [GW-1:0] G_SAT  = GW'(GRACE_CYCLES + 1);
    localparam logic [HW-1:0] H_MIN  = HW'(RECOVER_CYCLES + 2);

    logic [GW-1:0] ce_low, we_low;
    logic [HW-1:0] up_cnt;

    // Count consecutive low cycles of each output outside normal operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_low <= '0;
            we_low <= '0;
        end else begin
            ce_low <= (!in_normal && !ceo_n) ? ((ce_low == G_SAT) ? ce_low : ce_low + 1'b1) : '0;
            we_low <= (!in_normal && !weo_n) ? ((we_low == G_SAT) ? we_low : we_low + 1'b1) : '0;
        end
    end

    // Count cycles since the power-fail flag returned high
    always_ff @(posedge clk) begin
        if (!rst_n || !pfo_n) begin
            up_cnt <= '0;
        end else if (up_cnt != H_MIN) begin
            up_cnt <= up_cnt + 1'b1;
        end
    end

    assert_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_normal && $past(in_normal)) |-> (ceo_n == cei_n && weo_n == wei_n));

    assert_flag_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pfo_n |=> !in_normal);

    assert_grace_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ce_low <= G_LIM);

    assert_grace_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we_low <= G_LIM);

    assert_no_reassert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_normal && !$past(in_normal) && $past(ceo_n) && $past(weo_n)) |-> (ceo_n && weo_n));

    assert_holdoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pfo_n && (up_cnt < H_MIN) && $past(ceo_n) && $past(weo_n)) |-> (ceo_n && weo_n));

endmodule

bind pf_strobe_gate pfg_checker #(
    .GRACE_CYCLES   (GRACE_CYCLES),
    .RECOVER_CYCLES (RECOVER_CYCLES)
) u_pfg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cei_n     (cei_n),
    .wei_n     (wei_n),
    .ceo_n     (ceo_n),
    .weo_n     (weo_n),
    .pfo_n     (pfo_n),
    .in_normal (in_normal)
);

// File: tb/test_pf_strobe_gate.sv
// Directed bench for pf_strobe_gate. Inputs change 2 ns after a rising
// edge; outputs are read 1 ns later. "After edge k" counts from the edge
// that precedes the pf_in change.
module test_pf_strobe_gate;

    localparam int unsigned G = 8;
    localparam int unsigned R = 20;

    logic clk = 1'b0;
    logic rst_n, pf_in, cei_n, wei_n;
    logic ceo_n, weo_n, pfo_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pf_strobe_gate #(
        .GRACE_CYCLES   (G),
        .RECOVER_CYCLES (R),
        .SYNC_STAGES    (2)
    ) i_pf_strobe_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .pf_in (pf_in),
        .cei_n (cei_n),
        .wei_n (wei_n),
        .ceo_n (ceo_n),
        .weo_n (weo_n),
        .pfo_n (pfo_n)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Supply returns: pfo_n timing, then hold-off edges (R2, R8)
    task automatic power_up(input string req);
        pf_in = 1'b0; cei_n = 1'b0; wei_n = 1'b0;
        tick(1); #1;
        check("R2", "pfo_n one edge after release", pfo_n, 1'b0);
        tick(1); #1;
        check("R2", "pfo_n two edges after release", pfo_n, 1'b1);
        tick(R + 1); #1;
        check(req, "ceo_n last hold-off edge", ceo_n, 1'b1);
        check(req, "weo_n last hold-off edge", weo_n, 1'b1);
        tick(1); #1;
        check(req, "ceo_n after hold-off", ceo_n, 1'b0);
        check(req, "weo_n after hold-off", weo_n, 1'b0);
        cei_n = 1'b1; wei_n = 1'b1; #1;
        check("R1", "ceo_n follows high", ceo_n, 1'b1);
        check("R1", "weo_n follows high", weo_n, 1'b1);
    endtask

    // R10: reset state and the start-up hold-off
    task automatic t_reset;
        rst_n = 1'b0; pf_in = 1'b1; cei_n = 1'b0; wei_n = 1'b0;
        tick(3); #1;
        check("R10", "pfo_n in reset", pfo_n, 1'b0);
        check("R10", "ceo_n in reset", ceo_n, 1'b1);
        check("R10", "weo_n in reset", weo_n, 1'b1);
        rst_n = 1'b1;
        power_up("R10");
    endtask

    // R1: pass-through for all strobe combinations
    task automatic t_follow;
        for (int k = 0; k < 4; k++) begin
            tick(1);
            cei_n = k[0]; wei_n = k[1]; #1;
            check("R1", "ceo_n pattern", ceo_n, k[0]);
            check("R1", "weo_n pattern", weo_n, k[1]);
        end
        tick(1); cei_n = 1'b1; wei_n = 1'b1;
    endtask

    // R3: idle strobes are blocked when the failure takes effect
    task automatic t_fail_idle;
        cei_n = 1'b1; wei_n = 1'b1; pf_in = 1'b1;
        tick(1); #1;
        check("R2", "pfo_n one edge after fail", pfo_n, 1'b1);
        tick(1); #1;
        check("R2", "pfo_n two edges after fail", pfo_n, 1'b0);
        tick(1);
        cei_n = 1'b0; wei_n = 1'b0; #1;
        check("R3", "ceo_n blocked", ceo_n, 1'b1);
        check("R3", "weo_n blocked", weo_n, 1'b1);
        tick(2); #1;
        check("R3", "ceo_n still blocked", ceo_n, 1'b1);
        power_up("R8");
    endtask

    // R4: active chip enable finishes its cycle
    task automatic t_fail_active;
        cei_n = 1'b0; wei_n = 1'b1; pf_in = 1'b1;
        tick(3); #1;
        check("R4", "ceo_n held low", ceo_n, 1'b0);
        check("R3", "weo_n idle blocked", weo_n, 1'b1);
        tick(2);
        cei_n = 1'b1; #1;
        check("R4", "ceo_n released on input rise", ceo_n, 1'b1);
        tick(1);
        cei_n = 1'b0; wei_n = 1'b0; #1;
        check("R7", "ceo_n stays high", ceo_n, 1'b1);
        check("R7", "weo_n stays high", weo_n, 1'b1);
        power_up("R8");
    endtask

    // R5: grace timeout on both strobes
    task automatic t_timeout;
        cei_n = 1'b0; wei_n = 1'b0; pf_in = 1'b1;
        tick(2 + G); #1;
        check("R5", "ceo_n low at last grace edge", ceo_n, 1'b0);
        check("R5", "weo_n low at last grace edge", weo_n, 1'b0);
        tick(1); #1;
        check("R5", "ceo_n forced high", ceo_n, 1'b1);
        check("R5", "weo_n forced high", weo_n, 1'b1);
        check("R2", "pfo_n low through failure", pfo_n, 1'b0);
        cei_n = 1'b1; #1;
        cei_n = 1'b0; #1;
        check("R7", "ceo_n after input toggle", ceo_n, 1'b1);
        tick(3); #1;
        check("R7", "weo_n later", weo_n, 1'b1);
        power_up("R8");
    endtask

    // R6: the two paths decide and time out independently
    task automatic t_lanes;
        cei_n = 1'b0; wei_n = 1'b0; pf_in = 1'b1;
        tick(4);
        wei_n = 1'b1; #1;
        check("R6", "weo_n released", weo_n, 1'b1);
        check("R6", "ceo_n still held", ceo_n, 1'b0);
        tick(G - 2); #1;
        check("R6", "ceo_n at last grace edge", ceo_n, 1'b0);
        tick(1); #1;
        check("R6", "ceo_n timed out", ceo_n, 1'b1);
        wei_n = 1'b0; #1;
        check("R7", "weo_n not re-asserted", weo_n, 1'b1);
        power_up("R8");
    endtask

    // R9: a new failure during hold-off restarts it
    task automatic t_fail_in_recovery;
        cei_n = 1'b0; wei_n = 1'b0; pf_in = 1'b1;
        tick(4 + G);
        cei_n = 1'b1; wei_n = 1'b1;
        tick(1);
        pf_in = 1'b0; cei_n = 1'b0; wei_n = 1'b0;
        tick(2); #1;
        check("R9", "pfo_n recovered", pfo_n, 1'b1);
        tick(5);
        pf_in = 1'b1;
        tick(2); #1;
        check("R9", "pfo_n low again", pfo_n, 1'b0);
        check("R9", "ceo_n blocked", ceo_n, 1'b1);
        tick(3);
        power_up("R9");
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        t_reset();
        t_follow();
        t_fail_idle();
        t_follow();
        t_fail_active();
        t_timeout();
        t_lanes();
        t_fail_in_recovery();
        t_follow();
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule